// File: doc/BRIEF.md
# Shared-Slave Arbiter with Idle Parking

This block decides which of up to sixteen masters owns a single shared slave port. Every master raises its own request bit. The master that currently owns the port pulses an end-of-access strobe when its transfer is over. The arbiter answers with a registered one-hot grant and the binary number of the owning master. Each slave in a system gets its own copy of the block, so ports are arbitrated independently.

When several masters compete, a selectable scheme picks the winner. The default is a rotating scheme whose search begins one position past the master served last and wraps around. The alternative is a fixed ranking in which the lowest number wins. Once an access ends, the grant can only move at that end-of-access point; it never changes while an access is running.

When nothing is pending after an access, a 2-bit parking mode decides where the port rests. It can disconnect completely, stay with the master served last, or move to a programmed master. A master that finds the port already parked on it starts at once, with no arbitration cycle. Every other master waits one registered cycle for its grant.

Top module: `slave_port_arbiter`

## Requirements
- R1: While `rst_i` is high and on the first cycle after it falls, `gnt_o` is all zero and `gnt_idx_o` is 0.
- R2: `gnt_o` has at most one bit set, and when a bit is set `gnt_idx_o` gives its position.
- R3: When the port is idle and not parked on a requester, the winning requester's grant appears after the first rising edge at which its request is seen, which is exactly one cycle of latency.
- R4: Once an access has started, the grant holds until `access_done_i` is seen high. `access_done_i` has no effect while no access is running.
- R5: With `fixed_prio_i` = 0, the winner is the first requester found by searching upward from one past the master granted last, wrapping from N_MASTERS-1 back to 0. Before any grant, the search starts at 0.
- R6: With `fixed_prio_i` = 1, the requesting master with the lowest number wins.
- R7: With `park_mode_i` = 2'b00 or 2'b11, when an access ends and no request is pending, `gnt_o` goes to zero.
- R8: With `park_mode_i` = 2'b01, an idle port is granted to the master granted last. If no master has been granted since reset, the port stays disconnected.
- R9: With `park_mode_i` = 2'b10, an idle port is granted to master `park_idx_i`, and it follows a change of `park_idx_i` one cycle later. An index at or above N_MASTERS makes the port behave as with mode 2'b00.
- R10: An idle port that is parked on a master which then requests keeps its grant unchanged, and the access starts in that same cycle. That master wins even if other masters request at the same time.
- R11: A requester that the idle port is not parked on gets its grant one cycle after the request, so the parked grant is still visible in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | N_MASTERS | Request bit for each master |
| access_done_i | input | 1 | End-of-access strobe from the master that holds the grant |
| park_mode_i | input | 2 | Idle parking: 00 none, 01 last master, 10 fixed master, 11 none |
| park_idx_i | input | 4 | Master number used when parking mode is 10 |
| fixed_prio_i | input | 1 | 0 selects rotating order, 1 selects lowest-number-wins |
| gnt_o | output | N_MASTERS | One-hot registered grant, zero when disconnected |
| gnt_idx_o | output | 4 | Number of the granted master, 0 when disconnected |

## Verification
Some properties are checked on every cycle. The grant must never have more than one bit set, it must stay frozen during an access, and an access must always have an owner. After an idle request the grant must land on one of the requesters. On the cycles where an access ends with nothing pending, the checks also confirm a disconnect or a move to the fixed master, and a parked requester must keep its grant. Other behaviours need ordered histories that only the directed scenarios create. These include the rotating order across several handoffs, with its wrap past the top master number. They also include parking on the last master, the empty parking state before any grant, an out-of-range fixed index, and the one-cycle penalty for a master that is not parked.

// File: rtl/spa_pkg.sv
package spa_pkg;

    localparam int IDX_W       = 4;
    localparam int MAX_MASTERS = 16;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'b00,
        PARK_LAST  = 2'b01,
        PARK_FIXED = 2'b10
    } park_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } owner_t;

    // Code 2'b11 is reserved and folds onto the disconnect policy.
    function automatic park_e decode_park(input logic [1:0] code);
        case (code)
            2'b01:   return PARK_LAST;
            2'b10:   return PARK_FIXED;
            default: return PARK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spa_pick.sv
module spa_pick
    import spa_pkg::*;
#(
    parameter int N_MASTERS = 8
) (
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 fixed_prio_i,
    input  owner_t               last_i,
    output owner_t               win_o
);

    localparam logic [IDX_W:0] N_L = (IDX_W+1)'(N_MASTERS);

    logic [IDX_W:0]     after_last;
    logic [IDX_W:0]     start;
    logic [N_MASTERS-1:0] rot;

    always_comb begin
        after_last = {1'b0, last_i.idx} + (IDX_W+1)'(1);
        if (fixed_prio_i || !last_i.valid || after_last >= N_L)
            start = '0;
        else
            start = after_last;
        // Rotate so that bit 0 is the first candidate of the search.
        rot = N_MASTERS'({req_i, req_i} >> start);
    end

    always_comb begin
        int c;
        win_o = '0;
        for (int k = 0; k < N_MASTERS; k++) begin
            c = int'(start) + k;
            if (c >= N_MASTERS) c = c - N_MASTERS;
            if (!win_o.valid && rot[k]) begin
                win_o.valid = 1'b1;
                win_o.idx   = IDX_W'(c);
            end
        end
    end

endmodule

// File: rtl/spa_park.sv
module spa_park
    import spa_pkg::*;
#(
    parameter int N_MASTERS = 8
) (
    input  logic [1:0]       mode_i,
    input  logic [IDX_W-1:0] fix_idx_i,
    input  owner_t           last_i,
    output owner_t           park_o
);

    localparam logic [IDX_W:0] N_L = (IDX_W+1)'(N_MASTERS);

    always_comb begin
        park_o = '0;
        case (decode_park(mode_i))
            PARK_LAST:  park_o = last_i;
            PARK_FIXED: begin
                if ({1'b0, fix_idx_i} < N_L) begin
                    park_o.valid = 1'b1;
                    park_o.idx   = fix_idx_i;
                end
            end
            default:    park_o = '0;
        endcase
    end

endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter
    import spa_pkg::*;
#(
    parameter int N_MASTERS = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 access_done_i,
    input  logic [1:0]           park_mode_i,
    input  logic [IDX_W-1:0]     park_idx_i,
    input  logic                 fixed_prio_i,
    output logic [N_MASTERS-1:0] gnt_o,
    output logic [IDX_W-1:0]     gnt_idx_o
);

    localparam logic [IDX_W:0] N_L = (IDX_W+1)'(N_MASTERS);

    owner_t cur_q, cur_d;
    owner_t last_q, last_d;
    logic   busy_q, busy_d;
    owner_t win, park;
    logic   owner_req;
    logic   parked_hit;
    logic   rearb;

    spa_pick #(.N_MASTERS(N_MASTERS)) u_pick (
        .req_i        (req_i),
        .fixed_prio_i (fixed_prio_i),
        .last_i       (last_q),
        .win_o        (win)
    );

    spa_park #(.N_MASTERS(N_MASTERS)) u_park (
        .mode_i    (park_mode_i),
        .fix_idx_i (park_idx_i),
        .last_i    (last_q),
        .park_o    (park)
    );

    always_comb begin
        owner_req = 1'b0;
        for (int i = 0; i < N_MASTERS; i++)
            if (cur_q.valid && cur_q.idx == IDX_W'(i) && req_i[i])
                owner_req = 1'b1;
    end

    assign parked_hit = !busy_q && owner_req;
    assign rearb      = (busy_q && access_done_i) || (!busy_q && !parked_hit);

    always_comb begin
        cur_d  = cur_q;
        last_d = last_q;
        busy_d = busy_q;
        if (parked_hit) begin
            busy_d = 1'b1;
            last_d = cur_q;
        end else if (rearb) begin
            if (win.valid) begin
                cur_d  = win;
                last_d = win;
                busy_d = 1'b1;
            end else begin
                cur_d  = park;
                busy_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q  <= '0;
            last_q <= '0;
            busy_q <= 1'b0;
        end else begin
            cur_q  <= cur_d;
            last_q <= last_d;
            busy_q <= busy_d;
        end
    end

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_gnt
        assign gnt_o[g] = cur_q.valid && (cur_q.idx == IDX_W'(g));
    end
    assign gnt_idx_o = cur_q.idx;

    // R2
    a_r2_grant_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(gnt_o));

    // R4
    a_r4_hold_during_access: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_q && !access_done_i) |=> $stable(gnt_o));

    a_r4_access_has_owner: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_q |-> (gnt_o != '0));

    // R3
    a_r3_idle_grant_to_requester: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_q && !parked_hit && req_i != '0) |=> (busy_q && (gnt_o & $past(req_i)) != '0));

    // R7
    a_r7_disconnect_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_q && access_done_i && req_i == '0 && decode_park(park_mode_i) == PARK_NONE)
        |=> (gnt_o == '0));

    // R9
    a_r9_fixed_park: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_q && access_done_i && req_i == '0 && decode_park(park_mode_i) == PARK_FIXED
         && {1'b0, park_idx_i} < N_L)
        |=> (gnt_o != '0 && gnt_idx_o == $past(park_idx_i)));

    // R10
    a_r10_parked_hit_keeps_grant: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_q && (req_i & gnt_o) != '0) |=> ($stable(gnt_o) && busy_q));

endmodule

// File: tb/sim_slave_port_arbiter.sv
`timescale 1ns/1ps
module sim_slave_port_arbiter;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req;
    logic         done;
    logic [1:0]   mode;
    logic [3:0]   pidx;
    logic         fp;
    logic [N-1:0] gnt;
    logic [3:0]   gidx;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    slave_port_arbiter #(.N_MASTERS(N)) u0 (
        .clk_i         (clk),
        .rst_i         (rst),
        .req_i         (req),
        .access_done_i (done),
        .park_mode_i   (mode),
        .park_idx_i    (pidx),
        .fixed_prio_i  (fp),
        .gnt_o         (gnt),
        .gnt_idx_o     (gidx)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; req = '0; done = 1'b0; mode = 2'b00; pidx = '0; fp = 1'b0;
        step(3);
        check("R1 grant in reset", int'(gnt), 0);
        rst = 1'b0;
        step(1);
        check("R1 grant after reset", int'(gnt), 0);
        check("R1 index after reset", int'(gidx), 0);
        mode = 2'b01;
        step(3);
        check("R8 no park before any grant", int'(gnt), 0);
        mode = 2'b00;
    endtask

    task automatic t_basic();
        req = 8'b0000_0100;
        step(1);
        check("R3 grant one cycle after request", int'(gnt), 4);
        check("R2 index matches grant", int'(gidx), 2);
        step(3);
        check("R4 grant held during access", int'(gnt), 4);
        done = 1'b1; req = '0;
        step(1);
        check("R7 disconnect after access", int'(gnt), 0);
        step(2);
        check("R4 done ignored while idle", int'(gnt), 0);
        done = 1'b0;
    endtask

    task automatic t_round_robin();
        req = 8'b0110_0010;
        step(1);
        check("R5 search after master 2", int'(gidx), 5);
        done = 1'b1;
        step(1);
        check("R5 next after 5", int'(gidx), 6);
        step(1);
        check("R5 wrap to 1", int'(gidx), 1);
        step(1);
        check("R5 next after 1", int'(gidx), 5);
        req = '0;
        step(1);
        check("R7 disconnect after rotation", int'(gnt), 0);
        done = 1'b0;
    endtask

    task automatic t_fixed_prio();
        fp = 1'b1;
        req = 8'b0100_1000;
        step(1);
        check("R6 lowest wins", int'(gidx), 3);
        done = 1'b1;
        step(1);
        check("R6 lowest wins again", int'(gidx), 3);
        req = 8'b0100_0000;
        step(1);
        check("R6 only requester", int'(gidx), 6);
        req = '0;
        step(1);
        check("R7 disconnect", int'(gnt), 0);
        done = 1'b0; fp = 1'b0;
    endtask

    task automatic t_last_master();
        mode = 2'b01;
        step(1);
        check("R8 park on last master 6", int'(gnt), 8'h40);
        req = 8'b0100_0010;
        #1;
        check("R10 parked grant in request cycle", int'(gidx), 6);
        step(1);
        check("R10 parked master keeps grant", int'(gnt), 8'h40);
        done = 1'b1; req = 8'b0000_0010;
        step(1);
        check("R5 handoff to 1", int'(gidx), 1);
        req = '0;
        step(1);
        check("R8 park on last master 1", int'(gnt), 8'h02);
        done = 1'b0;
        req = 8'b0001_0000;
        #1;
        check("R11 old park still visible", int'(gidx), 1);
        step(1);
        check("R11 grant after one cycle", int'(gnt), 8'h10);
        done = 1'b1; req = '0;
        step(1);
        check("R8 park on last master 4", int'(gnt), 8'h10);
        done = 1'b0;
    endtask

    task automatic t_fixed_master();
        mode = 2'b10; pidx = 4'd3;
        step(1);
        check("R9 park on fixed 3", int'(gnt), 8'h08);
        pidx = 4'd5;
        step(1);
        check("R9 follows index change", int'(gnt), 8'h20);
        pidx = 4'd12;
        step(1);
        check("R9 out of range disconnects", int'(gnt), 0);
        pidx = 4'd2;
        step(1);
        check("R9 park on fixed 2", int'(gnt), 8'h04);
        req = 8'b1000_0100;
        step(1);
        check("R10 fixed master proceeds", int'(gnt), 8'h04);
        done = 1'b1; req = 8'b1000_0000;
        step(1);
        check("R5 handoff to 7", int'(gidx), 7);
        req = '0;
        step(1);
        check("R9 back to fixed not last", int'(gnt), 8'h04);
        done = 1'b0;
        req = 8'b0000_0001;
        #1;
        check("R11 fixed park visible", int'(gidx), 2);
        step(1);
        check("R11 master 0 after one cycle", int'(gnt), 8'h01);
        done = 1'b1; req = '0; mode = 2'b11;
        step(1);
        check("R7 mode 11 disconnects", int'(gnt), 0);
        done = 1'b0;
        step(1);
        check("R7 mode 11 stays disconnected", int'(gnt), 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_round_robin();
        t_fixed_prio();
        t_last_master();
        t_fixed_master();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule